// File: doc/BRIEF.md
# PWM Trip-Zone Fault Handler

This block sits between a two-channel PWM waveform generator and the output pads, and takes control of both channel outputs when a fault is reported. Six active-low fault inputs are each routed to one of two trip classes or left unused. A latched trip holds the outputs in their programmed fault state until software clears it. A periodic trip releases by itself at the first counter-zero event from the time-base after its fault input has gone away. While any trip is in force, output A and output B are each driven to a level chosen separately for that output: high, low, high-impedance (shown as a deasserted output enable), or left unchanged.

Software sees three sticky flags: latched-trip, periodic-trip and interrupt. It can clear each flag, inject a trip of either class with a one-cycle force pulse, and bypass the whole block. The interrupt request is the interrupt flag. It is set by a trip event of a class whose interrupt enable is on, and it stays asserted until it is cleared.

The trip controller has three states. `ST_RUN`: no trip is held. `ST_CYCLE`: a periodic trip is held. `ST_LATCH`: a latched trip is held. The transitions are:
- `ST_RUN` to `ST_LATCH` on any latched source.
- `ST_RUN` to `ST_CYCLE` on a periodic source.
- `ST_CYCLE` to `ST_LATCH` on a latched source.
- `ST_CYCLE` to `ST_RUN` on `ctr_zero` with no periodic source active.
- `ST_LATCH` to `ST_RUN` on `clr_ost` with no source of either class active.
- `ST_LATCH` to `ST_CYCLE` on `clr_ost` while only a periodic source is active.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset, `flag_ost`, `flag_cbc` and `irq` are 0. Both outputs pass their PWM input through, with output enable 1.
- R2: A trip input is active when it is low. An input that is enabled in neither `ost_sel` nor `cbc_sel` has no effect on the outputs or the flags.
- R3: An active input enabled in `ost_sel` forces the outputs in the same cycle, with no clock edge needed. `flag_ost` is set at the next clock edge.
- R4: A latched trip keeps the outputs forced after its input is released, and `ctr_zero` does not release it. It ends only at an edge where `clr_ost` is 1 and no latched source is active.
- R5: An active input enabled in `cbc_sel` forces the outputs while it is low. After it is released, the outputs stay forced up to and including the first clock edge where `ctr_zero` is 1 and no periodic source is active. A `ctr_zero` that arrives while the input is still low does not release the trip.
- R6: `flag_cbc` is set by a periodic trip event and stays set until `clr_cbc`, whether or not the trip has released.
- R7: The action code for each output (`act_a`, `act_b`) takes effect while a trip is in force. Code 0 passes the PWM input through. Code 1 drives 1. Code 2 drives 0. Code 3 drives 0 with output enable 0. The two outputs are set independently.
- R8: An input enabled in both `ost_sel` and `cbc_sel` acts only as a latched trip.
- R9: `irq` is set at the edge after a latched event while `ie_ost`=1, or after a periodic event while `ie_cbc`=1. It stays set until `clr_int`. Events whose class enable is 0 do not set it.
- R10: A one-cycle pulse on `frc_ost` or `frc_cbc` starts a trip of that class, exactly as an active input would.
- R11: While `bypass`=1, both outputs pass their PWM input through with output enable 1, and no flag is set.
- R12: When a flag's clear arrives in the same cycle as an event that sets that flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_a_in | input | 1 | Waveform for channel A |
| pwm_b_in | input | 1 | Waveform for channel B |
| trip_n | input | 6 | Fault inputs, active low, already synchronized |
| ost_sel | input | 6 | Per-input enable as a latched trip |
| cbc_sel | input | 6 | Per-input enable as a periodic trip |
| act_a | input | 2 | Fault action code for channel A |
| act_b | input | 2 | Fault action code for channel B |
| bypass | input | 1 | Disable all fault handling |
| ctr_zero | input | 1 | Time-base counter-zero event |
| ie_ost | input | 1 | Interrupt enable for latched trips |
| ie_cbc | input | 1 | Interrupt enable for periodic trips |
| frc_ost | input | 1 | Force a latched trip |
| frc_cbc | input | 1 | Force a periodic trip |
| clr_ost | input | 1 | Clear the latched flag and trip |
| clr_cbc | input | 1 | Clear the periodic flag |
| clr_int | input | 1 | Clear the interrupt flag |
| pwm_a_out | output | 1 | Channel A level |
| pwm_a_oe | output | 1 | Channel A output enable |
| pwm_b_out | output | 1 | Channel B level |
| pwm_b_oe | output | 1 | Channel B output enable |
| flag_ost | output | 1 | Latched-trip flag |
| flag_cbc | output | 1 | Periodic-trip flag |
| irq | output | 1 | Interrupt request (global flag) |

## Verification
The hardest case to reach is the periodic trip's hold window. The input has been released, but the outputs must stay forced until a counter-zero event, while a counter-zero that comes during the fault must not release it. The bench drives `ctr_zero` by hand rather than from a real time-base. It places one pulse while the input is still low, checks the outputs again after the release but before any pulse, and then sends the pulse that releases the trip. Clear-against-set collisions are produced by holding a fault low during the clear pulse.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_HIGH = 2'd1,
        ACT_LOW  = 2'd2,
        ACT_HIZ  = 2'd3
    } force_act_t;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_CYCLE = 2'd1,
        ST_LATCH = 2'd2
    } guard_state_t;

endpackage

// File: rtl/trip_decode.sv
module trip_decode #(
    parameter int N_TRIP = 6
) (
    input  logic [N_TRIP-1:0] trip_n,
    input  logic [N_TRIP-1:0] ost_sel,
    input  logic [N_TRIP-1:0] cbc_sel,
    input  logic              frc_ost,
    input  logic              frc_cbc,
    input  logic              bypass,
    output logic              ost_now,
    output logic              cbc_now
);
    logic [N_TRIP-1:0] ost_hit;
    logic [N_TRIP-1:0] cbc_hit;

    // Per-input classification; latched class wins when both selects are set.
    for (genvar i = 0; i < N_TRIP; i++) begin : g_src
        assign ost_hit[i] = ~trip_n[i] & ost_sel[i];
        assign cbc_hit[i] = ~trip_n[i] & cbc_sel[i] & ~ost_sel[i];
    end

    always_comb begin
        ost_now = ~bypass & ((|ost_hit) | frc_ost);
        cbc_now = ~bypass & ((|cbc_hit) | frc_cbc);
    end
endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
    import fault_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ost_now,
    input  logic         cbc_now,
    input  logic         ctr_zero,
    input  logic         clr_ost,
    output guard_state_t state,
    output logic         trip_hold
);
    guard_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (ost_now)      nxt = ST_LATCH;
                else if (cbc_now) nxt = ST_CYCLE;
            end
            ST_CYCLE: begin
                if (ost_now)                    nxt = ST_LATCH;
                else if (ctr_zero && !cbc_now)  nxt = ST_RUN;
            end
            ST_LATCH: begin
                if (clr_ost && !ost_now) nxt = cbc_now ? ST_CYCLE : ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_RUN:   trip_hold = 1'b0;
            ST_CYCLE: trip_hold = 1'b1;
            ST_LATCH: trip_hold = 1'b1;
            default:  trip_hold = 1'b1;
        endcase
    end

    assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && !clr_ost) |=> state == ST_LATCH);

    assert_cycle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CYCLE && !ctr_zero) |=> state != ST_RUN);

    assert_cycle_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CYCLE && ctr_zero && !cbc_now && !ost_now) |=> state == ST_RUN);
endmodule

// File: rtl/guard_flags.sv
module guard_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ost_now,
    input  logic cbc_now,
    input  logic ie_ost,
    input  logic ie_cbc,
    input  logic clr_ost,
    input  logic clr_cbc,
    input  logic clr_int,
    output logic flag_ost,
    output logic flag_cbc,
    output logic flag_int
);
    logic int_evt;
    assign int_evt = (ost_now & ie_ost) | (cbc_now & ie_cbc);

    // Set has priority over clear in every flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_ost <= 1'b0;
            flag_cbc <= 1'b0;
            flag_int <= 1'b0;
        end else begin
            if (ost_now)      flag_ost <= 1'b1;
            else if (clr_ost) flag_ost <= 1'b0;
            if (cbc_now)      flag_cbc <= 1'b1;
            else if (clr_cbc) flag_cbc <= 1'b0;
            if (int_evt)      flag_int <= 1'b1;
            else if (clr_int) flag_int <= 1'b0;
        end
    end

    assert_ost_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ost && !clr_ost) |=> flag_ost);

    assert_cbc_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_cbc && !clr_cbc) |=> flag_cbc);

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ost_now && clr_ost) |=> flag_ost);

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_int) |-> $past((ost_now && ie_ost) || (cbc_now && ie_cbc)));
endmodule

// File: rtl/out_force.sv
module out_force
    import fault_guard_pkg::*;
(
    input  logic       pwm_in,
    input  logic       force_en,
    input  logic [1:0] act,
    output logic       pwm_out,
    output logic       pwm_oe
);
    force_act_t code;
    assign code = force_act_t'(act);

    always_comb begin
        pwm_out = pwm_in;
        pwm_oe  = 1'b1;
        if (force_en) begin
            unique case (code)
                ACT_NONE: begin pwm_out = pwm_in; pwm_oe = 1'b1; end
                ACT_HIGH: begin pwm_out = 1'b1;   pwm_oe = 1'b1; end
                ACT_LOW:  begin pwm_out = 1'b0;   pwm_oe = 1'b1; end
                ACT_HIZ:  begin pwm_out = 1'b0;   pwm_oe = 1'b0; end
                default:  begin pwm_out = 1'b0;   pwm_oe = 1'b0; end
            endcase
        end
    end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
    import fault_guard_pkg::*;
#(
    parameter int N_TRIP = 6,
    parameter int ACT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_a_in,
    input  logic              pwm_b_in,
    input  logic [N_TRIP-1:0] trip_n,
    input  logic [N_TRIP-1:0] ost_sel,
    input  logic [N_TRIP-1:0] cbc_sel,
    input  logic [ACT_W-1:0]  act_a,
    input  logic [ACT_W-1:0]  act_b,
    input  logic              bypass,
    input  logic              ctr_zero,
    input  logic              ie_ost,
    input  logic              ie_cbc,
    input  logic              frc_ost,
    input  logic              frc_cbc,
    input  logic              clr_ost,
    input  logic              clr_cbc,
    input  logic              clr_int,
    output logic              pwm_a_out,
    output logic              pwm_a_oe,
    output logic              pwm_b_out,
    output logic              pwm_b_oe,
    output logic              flag_ost,
    output logic              flag_cbc,
    output logic              irq
);
    localparam int N_CH = 2;

    logic         ost_now, cbc_now, trip_hold, force_en;
    guard_state_t state;

    trip_decode #(.N_TRIP(N_TRIP)) u_dec (
        .trip_n(trip_n), .ost_sel(ost_sel), .cbc_sel(cbc_sel),
        .frc_ost(frc_ost), .frc_cbc(frc_cbc), .bypass(bypass),
        .ost_now(ost_now), .cbc_now(cbc_now)
    );

    guard_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ost_now(ost_now), .cbc_now(cbc_now),
        .ctr_zero(ctr_zero), .clr_ost(clr_ost),
        .state(state), .trip_hold(trip_hold)
    );

    guard_flags u_flags (
        .clk(clk), .rst_n(rst_n), .ost_now(ost_now), .cbc_now(cbc_now),
        .ie_ost(ie_ost), .ie_cbc(ie_cbc),
        .clr_ost(clr_ost), .clr_cbc(clr_cbc), .clr_int(clr_int),
        .flag_ost(flag_ost), .flag_cbc(flag_cbc), .flag_int(irq)
    );

    // Live sources act at once; the held state keeps the force afterwards.
    assign force_en = ~bypass & (trip_hold | ost_now | cbc_now);

    logic [N_CH-1:0]       ch_in, ch_out, ch_oe;
    logic [ACT_W*N_CH-1:0] ch_act;
    assign ch_in  = {pwm_b_in, pwm_a_in};
    assign ch_act = {act_b, act_a};

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        out_force u_out (
            .pwm_in(ch_in[c]), .force_en(force_en),
            .act(ch_act[c*ACT_W +: ACT_W]),
            .pwm_out(ch_out[c]), .pwm_oe(ch_oe[c])
        );
    end

    assign pwm_a_out = ch_out[0];
    assign pwm_a_oe  = ch_oe[0];
    assign pwm_b_out = ch_out[1];
    assign pwm_b_oe  = ch_oe[1];

    assert_bypass_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (pwm_a_out == pwm_a_in && pwm_a_oe && pwm_b_out == pwm_b_in && pwm_b_oe));

    assert_hiz_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_a_oe |-> act_a == ACT_HIZ) and (!pwm_b_oe |-> act_b == ACT_HIZ));

    assert_latched_forces_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ost && !bypass && act_a == ACT_HIGH) |-> (pwm_a_out && pwm_a_oe));
endmodule

// File: tb/pwm_fault_guard_test.sv
module pwm_fault_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_a_in = 1'b0, pwm_b_in = 1'b1;
    logic [5:0] trip_n = '1, ost_sel = '0, cbc_sel = '0;
    logic [1:0] act_a = 2'd1, act_b = 2'd2;
    logic       bypass = 0, ctr_zero = 0, ie_ost = 0, ie_cbc = 0;
    logic       frc_ost = 0, frc_cbc = 0, clr_ost = 0, clr_cbc = 0, clr_int = 0;
    logic       pwm_a_out, pwm_a_oe, pwm_b_out, pwm_b_oe, flag_ost, flag_cbc, irq;

    int  nchk = 0, nerr = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    pwm_fault_guard uut (
        .clk(clk), .rst_n(rst_n), .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
        .trip_n(trip_n), .ost_sel(ost_sel), .cbc_sel(cbc_sel),
        .act_a(act_a), .act_b(act_b), .bypass(bypass), .ctr_zero(ctr_zero),
        .ie_ost(ie_ost), .ie_cbc(ie_cbc), .frc_ost(frc_ost), .frc_cbc(frc_cbc),
        .clr_ost(clr_ost), .clr_cbc(clr_cbc), .clr_int(clr_int),
        .pwm_a_out(pwm_a_out), .pwm_a_oe(pwm_a_oe),
        .pwm_b_out(pwm_b_out), .pwm_b_oe(pwm_b_oe),
        .flag_ost(flag_ost), .flag_cbc(flag_cbc), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expected channel level/enable from the action codes of R7.
    function automatic logic exp_out(input logic [1:0] code, input logic pin);
        case (code)
            2'd0: return pin;
            2'd1: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_oe(input logic [1:0] code);
        return code != 2'd3;
    endfunction

    task automatic cleanup();
        trip_n = '1; frc_ost = 0; frc_cbc = 0;
        clr_ost = 1; clr_cbc = 1; clr_int = 1; ctr_zero = 1;
        step();
        clr_ost = 0; clr_cbc = 0; clr_int = 0; ctr_zero = 0;
        ost_sel = '0; cbc_sel = '0; ie_ost = 0; ie_cbc = 0;
        act_a = 2'd1; act_b = 2'd2; bypass = 0;
        #1;
    endtask

    task automatic t_reset();
        chk("R1", "flag_ost", flag_ost, 0);
        chk("R1", "flag_cbc", flag_cbc, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "a pass", {pwm_a_out, pwm_a_oe}, {pwm_a_in, 1'b1});
        chk("R1", "b pass", {pwm_b_out, pwm_b_oe}, {pwm_b_in, 1'b1});
    endtask

    task automatic t_ignored();
        trip_n = '0; #1;
        chk("R2", "unselected a", {pwm_a_out, pwm_a_oe}, {1'b0, 1'b1});
        step();
        chk("R2", "unselected flags", {flag_ost, flag_cbc, irq}, 3'b000);
        cleanup();
    endtask

    task automatic t_oneshot();
        ost_sel = 6'b000100;
        trip_n[2] = 0; #1;
        chk("R3", "comb force a", {pwm_a_out, pwm_a_oe}, 2'b11);
        chk("R3", "comb force b", {pwm_b_out, pwm_b_oe}, 2'b01);
        step();
        chk("R3", "flag_ost set", flag_ost, 1);
        clr_ost = 1; step(); clr_ost = 0;
        chk("R12", "clear vs active source", flag_ost, 1);
        trip_n[2] = 1; step();
        ctr_zero = 1; step(); ctr_zero = 0; #1;
        chk("R4", "held after release+zero", {pwm_a_out, pwm_b_out}, 2'b10);
        chk("R4", "flag held", flag_ost, 1);
        clr_ost = 1; step(); clr_ost = 0; #1;
        chk("R4", "released by clear", {pwm_a_out, pwm_b_out}, 2'b01);
        chk("R4", "flag cleared", flag_ost, 0);
        cleanup();
    endtask

    task automatic t_cbc();
        cbc_sel = 6'b000001;
        trip_n[0] = 0; #1;
        chk("R5", "comb force a", pwm_a_out, 1);
        step();
        chk("R6", "flag_cbc set", flag_cbc, 1);
        ctr_zero = 1; step(); ctr_zero = 0; #1;
        chk("R5", "zero while active", pwm_a_out, 1);
        trip_n[0] = 1; step(); #1;
        chk("R5", "held until zero", pwm_a_out, 1);
        step();
        chk("R5", "still held", pwm_a_out, 1);
        ctr_zero = 1; step(); ctr_zero = 0; #1;
        chk("R5", "released at zero", {pwm_a_out, pwm_b_out}, 2'b01);
        chk("R6", "flag survives release", flag_cbc, 1);
        clr_cbc = 1; step(); clr_cbc = 0;
        chk("R6", "flag cleared", flag_cbc, 0);
        cleanup();
    endtask

    task automatic t_actions();
        for (int k = 0; k < 4; k++) begin
            act_a = 2'(k); act_b = 2'(3 - k);
            ost_sel = 6'b000010; trip_n[1] = 0; #1;
            chk("R7", "a level/oe", {pwm_a_out, pwm_a_oe},
                {exp_out(act_a, pwm_a_in), exp_oe(act_a)});
            chk("R7", "b level/oe", {pwm_b_out, pwm_b_oe},
                {exp_out(act_b, pwm_b_in), exp_oe(act_b)});
            step();
            cleanup();
        end
    endtask

    task automatic t_overlap();
        ost_sel = 6'b001000; cbc_sel = 6'b001000;
        trip_n[3] = 0; step(); trip_n[3] = 1;
        ctr_zero = 1; step(); ctr_zero = 0; #1;
        chk("R8", "flags", {flag_ost, flag_cbc}, 2'b10);
        chk("R8", "still latched", pwm_a_out, 1);
        cleanup();
    endtask

    task automatic t_irq();
        cbc_sel = 6'b010000;
        trip_n[4] = 0; step(); trip_n[4] = 1;
        chk("R9", "disabled class", irq, 0);
        cleanup();
        ie_cbc = 1; cbc_sel = 6'b010000;
        trip_n[4] = 0; step(); trip_n[4] = 1;
        chk("R9", "irq set", irq, 1);
        step();
        chk("R9", "irq sticky", irq, 1);
        trip_n[4] = 0; clr_int = 1; step(); clr_int = 0; trip_n[4] = 1;
        chk("R12", "irq set beats clear", irq, 1);
        clr_int = 1; step(); clr_int = 0;
        chk("R9", "irq cleared", irq, 0);
        cleanup();
    endtask

    task automatic t_force();
        frc_ost = 1; #1;
        chk("R10", "force ost comb", pwm_a_out, 1);
        step(); frc_ost = 0; #1;
        chk("R10", "force ost latched", {flag_ost, pwm_a_out}, 2'b11);
        cleanup();
        frc_cbc = 1; step(); frc_cbc = 0; #1;
        chk("R10", "force cbc", {flag_cbc, pwm_a_out}, 2'b11);
        ctr_zero = 1; step(); ctr_zero = 0; #1;
        chk("R10", "force cbc released", pwm_a_out, 0);
        cleanup();
    endtask

    task automatic t_bypass();
        bypass = 1; ost_sel = 6'b100000; ie_ost = 1;
        trip_n[5] = 0; #1;
        chk("R11", "pass a", {pwm_a_out, pwm_a_oe}, 2'b01);
        chk("R11", "pass b", {pwm_b_out, pwm_b_oe}, 2'b11);
        step();
        chk("R11", "no flags", {flag_ost, flag_cbc, irq}, 3'b000);
        cleanup();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1; #1;
        t_reset();
        t_ignored();
        t_oneshot();
        t_cbc();
        t_actions();
        t_overlap();
        t_irq();
        t_force();
        t_bypass();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule